// File: doc/BRIEF.md
# Low-Voltage Detect and Warning Controller

This block is the digital side of a supply monitor. An analog comparator pair reports whether the supply is below a detect threshold or below a warning threshold. Both comparator outputs are synchronized into the block's clock domain. A rising edge of either one sets a sticky event flag. Software sees the flags, and controls the block, through two 8-bit registers on a byte-wide bus with a combinational read port. The block drives back to the analog monitor the trip-point codes that software has chosen.

Each flag raises its own interrupt request when that channel's interrupt enable is set. The detect flag can also raise a reset request through a write-once enable. The block has two reset domains. Power-on reset clears everything, including the trip-point codes. Chip reset clears everything except those codes. While the low-power input is high, no new event is taken.

Top module: `lvd_warn_ctrl`

## Requirements
- R1: After reset, the detect register (address 0) reads 0x10, the warning register (address 1) reads 0x00, and every request output and trip code output is 0.
- R2: Bits [1:0] of the detect register hold the detect trip code and drive `det_trip_sel`. A write with code 00 or 01 stores it. A write with code 10 or 11 leaves the stored code unchanged.
- R3: Bits [1:0] of the warning register hold one of four warning trip codes and drive `warn_trip_sel`. Reserved bits read 0 and ignore writes: bits [4:2] of the warning register and bits [3:2] of the detect register.
- R4: A rising edge on a comparator input sets that channel's flag, read at bit 7 of its register. The flag becomes visible after the third rising clock edge that follows the input change.
- R5: Writing 1 to bit 6 of a register clears that register's flag. Writing 0 to bit 6 leaves the flag as it is, and bit 6 always reads 0.
- R6: If a flag is set and acknowledged in the same cycle, the flag ends the cycle set.
- R7: `det_irq` equals the detect flag AND bit 5 of the detect register. `warn_irq` equals the warning flag AND bit 5 of the warning register. `reset_req` equals the detect flag AND bit 4 of the detect register.
- R8: Bit 4 of the detect register (reset enable) resets to 1. The first write to the detect register after reset loads it, and every later write leaves it unchanged until the next reset.
- R9: Chip reset clears the flags, the enables and the write-once lock, but keeps both trip codes. Power-on reset also clears the trip codes.
- R10: While `low_power` is 1, no flag is set. A comparator that is still high when `low_power` falls, or when reset is released, counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| chip_rst_n | input | 1 | Chip reset, active low, keeps the trip codes |
| low_power | input | 1 | Suspends event detection while 1 |
| below_detect | input | 1 | Comparator: supply below detect threshold |
| below_warn | input | 1 | Comparator: supply below warning threshold |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| det_irq | output | 1 | Detect interrupt request |
| warn_irq | output | 1 | Warning interrupt request |
| reset_req | output | 1 | Reset request from a detect event |
| det_trip_sel | output | 2 | Detect trip code to the monitor |
| warn_trip_sel | output | 2 | Warning trip code to the monitor |

## Verification
All four codes are swept through both trip fields, with the reserved bits set in each write. This separates the filtered detect field from the open warning field and shows that the reserved bits stay at 0. The enables are stepped against flags that are set and cleared. This tells apart the two interrupt paths and the reset path, and shows that the write-once enable stays locked. Comparator edges are placed at an exact cycle, so the three-edge latency is checked, and the same-cycle set-against-acknowledge case is checked. Chip reset and power-on reset are applied in turn, and a comparator is held high across reset exit and across the end of low power, so each reset domain and each hidden-edge case shows its own result.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int REG_W    = 8;
  localparam int SEL_W    = 2;
  localparam int N_CHAN   = 2;
  localparam int CH_DET   = 0;
  localparam int CH_WARN  = 1;
  localparam int FLAG_BIT = 7;
  localparam int ACK_BIT  = 6;
  localparam int IE_BIT   = 5;
  localparam int RE_BIT   = 4;

  // detect trip codes with the upper bit set are reserved
  function automatic logic det_code_ok(input logic [SEL_W-1:0] code);
    return ~code[SEL_W-1];
  endfunction

  function automatic logic [REG_W-1:0] pack_reg(input logic flag, input logic ie,
                                                input logic re, input logic [SEL_W-1:0] sel);
    logic [REG_W-1:0] r;
    r = '0;
    r[FLAG_BIT]  = flag;
    r[IE_BIT]    = ie;
    r[RE_BIT]    = re;
    r[SEL_W-1:0] = sel;
    return r;
  endfunction
endpackage

// File: rtl/lvd_sync_edge.sv
module lvd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic suspend,
  output logic event_o
);
  logic [STAGES-1:0] sr;
  logic              qual;
  logic              qual_q;

  assign qual    = sr[STAGES-1] & ~suspend;
  assign event_o = qual & ~qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      qual_q <= 1'b0;
    end else begin
      sr     <= {sr[STAGES-2:0], din};
      qual_q <= qual;
    end
  end
endmodule

// File: rtl/lvd_flag.sv
module lvd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/lvd_warn_ctrl.sv
module lvd_warn_ctrl
  import lvd_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              chip_rst_n,
  input  logic              low_power,
  input  logic              below_detect,
  input  logic              below_warn,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              det_irq,
  output logic              warn_irq,
  output logic              reset_req,
  output logic [SEL_W-1:0]  det_trip_sel,
  output logic [SEL_W-1:0]  warn_trip_sel
);
  logic              sys_rst_n;
  logic              wr_det;
  logic              wr_warn;
  logic [N_CHAN-1:0] chan_cmp;
  logic [N_CHAN-1:0] chan_ack;
  logic [N_CHAN-1:0] chan_evt;
  logic [N_CHAN-1:0] chan_flag;
  logic [N_CHAN-1:0] chan_ie;
  logic              det_re;
  logic              re_locked;
  logic [SEL_W-1:0]  det_sel;
  logic [SEL_W-1:0]  warn_sel;
  wire               unused_wbits = ^{bus_wdata[3:2]};

  assign sys_rst_n = por_n & chip_rst_n;
  assign wr_det    = bus_wr && (bus_addr == ADDR_W'(0));
  assign wr_warn   = bus_wr && (bus_addr == ADDR_W'(1));

  assign chan_cmp[CH_DET]  = below_detect;
  assign chan_cmp[CH_WARN] = below_warn;
  assign chan_ack[CH_DET]  = wr_det  & bus_wdata[ACK_BIT];
  assign chan_ack[CH_WARN] = wr_warn & bus_wdata[ACK_BIT];

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    lvd_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (sys_rst_n),
      .din     (chan_cmp[c]),
      .suspend (low_power),
      .event_o (chan_evt[c])
    );
    lvd_flag i_flag (
      .clk    (clk),
      .rst_n  (sys_rst_n),
      .set_i  (chan_evt[c]),
      .clr_i  (chan_ack[c]),
      .flag_o (chan_flag[c])
    );
  end

  // chip-reset domain controls
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      chan_ie   <= '0;
      det_re    <= 1'b1;
      re_locked <= 1'b0;
    end else begin
      if (wr_det) begin
        chan_ie[CH_DET] <= bus_wdata[IE_BIT];
        re_locked       <= 1'b1;
        if (!re_locked) det_re <= bus_wdata[RE_BIT];
      end
      if (wr_warn) chan_ie[CH_WARN] <= bus_wdata[IE_BIT];
    end
  end

  // power-on-reset domain trip codes
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      det_sel  <= '0;
      warn_sel <= '0;
    end else begin
      if (wr_det && det_code_ok(bus_wdata[SEL_W-1:0])) det_sel <= bus_wdata[SEL_W-1:0];
      if (wr_warn) warn_sel <= bus_wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(0): bus_rdata = pack_reg(chan_flag[CH_DET], chan_ie[CH_DET], det_re, det_sel);
      ADDR_W'(1): bus_rdata = pack_reg(chan_flag[CH_WARN], chan_ie[CH_WARN], 1'b0, warn_sel);
      default:    bus_rdata = '0;
    endcase
  end

  assign det_irq       = chan_flag[CH_DET]  & chan_ie[CH_DET];
  assign warn_irq      = chan_flag[CH_WARN] & chan_ie[CH_WARN];
  assign reset_req     = chan_flag[CH_DET]  & det_re;
  assign det_trip_sel  = det_sel;
  assign warn_trip_sel = warn_sel;
endmodule

// File: rtl/lvd_warn_ctrl_chk.sv
module lvd_warn_ctrl_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              low_power,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_rdata,
  input logic              reset_req,
  input logic [1:0]        det_trip_sel,
  input logic [1:0]        chan_evt,
  input logic [1:0]        chan_flag,
  input logic              det_re,
  input logic              re_locked
);
  assert_flag_from_event_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(chan_flag[0]) |-> $past(chan_evt[0]));

  assert_ack_reads_zero_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    bus_rdata[6] == 1'b0);

  assert_reset_req_needs_flag_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    reset_req |-> chan_flag[0]);

  assert_write_once_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $past(re_locked) |-> $stable(det_re));

  assert_trip_held_R9: assert property (@(posedge clk) disable iff (!por_n)
    !($past(bus_wr) && ($past(bus_addr) == ADDR_W'(0))) |-> $stable(det_trip_sel));

  assert_no_event_low_power_R10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    low_power |-> (chan_evt == 2'b00));
endmodule

bind lvd_warn_ctrl lvd_warn_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk          (clk),
  .por_n        (por_n),
  .sys_rst_n    (sys_rst_n),
  .low_power    (low_power),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rdata    (bus_rdata),
  .reset_req    (reset_req),
  .det_trip_sel (det_trip_sel),
  .chan_evt     (chan_evt),
  .chan_flag    (chan_flag),
  .det_re       (det_re),
  .re_locked    (re_locked)
);

// File: tb/test_lvd_warn_ctrl.sv
module test_lvd_warn_ctrl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       chip_rst_n = 1'b0;
  logic       low_power = 1'b0;
  logic       below_detect = 1'b0;
  logic       below_warn = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       det_irq, warn_irq, reset_req;
  logic [1:0] det_trip_sel, warn_trip_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lvd_warn_ctrl i_lvd_warn_ctrl (
    .clk(clk), .por_n(por_n), .chip_rst_n(chip_rst_n), .low_power(low_power),
    .below_detect(below_detect), .below_warn(below_warn),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .det_irq(det_irq), .warn_irq(warn_irq), .reset_req(reset_req),
    .det_trip_sel(det_trip_sel), .warn_trip_sel(warn_trip_sel)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  // expected register image from the field layout in the requirements
  function automatic int img(input int flag, input int ie, input int re, input int sel);
    return (flag << 7) | (ie << 5) | (re << 4) | sel;
  endfunction

  initial begin
    logic [7:0] d;
    int exp_sel;
    @(negedge clk); step(2);
    por_n = 1'b1; chip_rst_n = 1'b1;
    @(negedge clk);

    rd(0, d); check("R1 det reg", d, 8'h10);
    rd(1, d); check("R1 warn reg", d, 8'h00);
    check("R1 outputs", {det_irq, warn_irq, reset_req, det_trip_sel, warn_trip_sel}, 0);

    // write-once: first write clears reset enable, second cannot set it
    wr(0, 8'h00); rd(0, d); check("R8 first write", d, 8'h00);
    wr(0, 8'h10); rd(0, d); check("R8 later write ignored", d, 8'h00);

    // detect code sweep with reserved bits set
    exp_sel = 0;
    for (int c = 0; c < 4; c++) begin
      wr(0, 8'(8'h0C | 8'h10 | c));
      if (c < 2) exp_sel = c;
      rd(0, d); check("R2 det code readback", d, img(0, 0, 0, exp_sel));
      check("R2 det trip output", det_trip_sel, exp_sel);
    end
    // warning code sweep with reserved bits set
    for (int c = 0; c < 4; c++) begin
      wr(1, 8'(8'h1C | c));
      rd(1, d); check("R3 warn code readback", d, c);
      check("R3 warn trip output", warn_trip_sel, c);
    end

    // detect event latency and interrupt
    wr(0, 8'h21);
    below_detect = 1'b1;
    step(2); rd(0, d); check("R4 flag not before third edge", d[7], 0);
    step(1); rd(0, d); check("R4 flag after third edge", d[7], 1);
    check("R7 det_irq", det_irq, 1);
    check("R7 reset_req with enable 0", reset_req, 0);
    wr(0, 8'h01); check("R7 det_irq with ie 0", det_irq, 0);
    wr(0, 8'h21);
    check("R5 write without ack keeps flag", det_irq, 1);
    wr(0, 8'h61); rd(0, d);
    check("R5 ack clears flag", d, img(0, 1, 0, 1));
    check("R5 det_irq after ack", det_irq, 0);
    below_detect = 1'b0; step(3);

    // same-cycle set and acknowledge on the warning channel
    wr(1, 8'h22);
    below_warn = 1'b1;
    step(2);
    wr(1, 8'h62);
    rd(1, d); check("R6 set beats ack", d, img(1, 1, 0, 2));
    check("R7 warn_irq", warn_irq, 1);
    wr(1, 8'h62); check("R5 warn ack", warn_irq, 0);
    below_warn = 1'b0; step(3);

    // chip reset keeps trip codes
    wr(1, 8'h23);
    chip_rst_n = 1'b0; step(2); chip_rst_n = 1'b1; @(negedge clk);
    rd(0, d); check("R9 det after chip reset", d, 8'h11);
    rd(1, d); check("R9 warn after chip reset", d, 8'h03);
    wr(0, 8'h11);
    below_detect = 1'b1; step(3);
    check("R7 reset_req", reset_req, 1);
    wr(0, 8'h41); rd(0, d); check("R8 lock after chip reset", d, 8'h11);
    below_detect = 1'b0; step(3);

    // power-on reset clears codes; comparator held through reset exit
    por_n = 1'b0; below_detect = 1'b1; step(2); por_n = 1'b1; @(negedge clk);
    check("R9 trip codes after por", {det_trip_sel, warn_trip_sel}, 0);
    step(1); rd(0, d); check("R10 level at reset exit, early", d[7], 0);
    step(2); rd(0, d); check("R10 level at reset exit", d, 8'h90);
    below_detect = 1'b0; wr(0, 8'h40); step(3);

    // low power suppresses, exit with level high counts
    low_power = 1'b1; below_warn = 1'b1; step(6);
    rd(1, d); check("R10 no flag in low power", d[7], 0);
    low_power = 1'b0; step(1);
    rd(1, d); check("R10 flag after low power exit", d[7], 1);
    rd(2, d); check("R3 unused address reads 0", d, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule